// File: doc/BRIEF.md
# Thread-Block Admission and Dispatch Unit

This unit sits between a grid-level launch queue and one streaming multiprocessor. Each launch request names a block, gives its shape in three dimensions and states how many registers every thread of the block needs. The unit admits the request only when the multiprocessor can hold it on four independent limits at once. Those limits are resident blocks, resident warps, resident threads and register-file words. While any one of them is short, the request waits at the head of the queue.

On admission the block's threads are numbered linearly, x fastest, then y, then z. They are cut into consecutive warps of a fixed width. A contiguous run of register-file chunks is reserved by first-fit search. The warps are then handed to the warp pool, one per cycle. Each warp carries its first thread index, its register base and a lane mask. A retirement request naming a resident block gives all of its resources back in one cycle.

Top module: `block_admit`

## Requirements
- R1: After reset no warp is presented, all resources are free, and a one-thread block with no registers is offered `req_ready` high.
- R2: A request is accepted (`req_valid` and `req_ready` high at a clock edge) only if four conditions all hold. Fewer than 8 blocks are resident. Resident warps plus the block's warps do not exceed 32. Resident threads plus the block's threads do not exceed 1536. A contiguous free run of the needed register chunks exists. Otherwise `req_ready` is low.
- R3: A request that does not fit keeps `req_ready` low for as long as it waits. It becomes acceptable in the cycle after a retirement frees enough resources.
- R4: The block's thread count is T = dx·dy·dz and its warp count is W = ceil(T/32). Warps 0..W-1 appear on consecutive cycles in ascending `warp_idx`, starting the cycle after acceptance. `warp_block` carries the block id. `warp_last` is high only on warp W-1.
- R5: `warp_tbase` of warp k is 32·k, the linear index of its first thread.
- R6: `warp_mask` is all ones for every warp except the last. The last warp has exactly the low T-32·(W-1) bits set, with bit j standing for lane j.
- R7: A block needs ceil(regs·T/256) chunks of 256 words. It receives the lowest-addressed free run of that length. Warp k gets `warp_rbase` = 256·start + 32·k·regs.
- R8: A retirement whose id matches a resident block frees that block's slot, warps, threads and chunks together in one cycle. A retirement with no matching resident id changes nothing.
- R9: `req_ready` stays low while a block's warps are being presented.
- R10: A block with a per-thread register count of zero takes no chunks and all its warps report `warp_rbase` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request fits and is accepted at this edge if valid |
| req_id | input | 8 | Block id |
| req_dx | input | 10 | Block extent in x |
| req_dy | input | 10 | Block extent in y |
| req_dz | input | 6 | Block extent in z |
| req_regs | input | 8 | Registers per thread |
| ret_valid | input | 1 | Retirement request present |
| ret_id | input | 8 | Id of the retiring block |
| warp_valid | output | 1 | A warp descriptor is presented this cycle |
| warp_block | output | 8 | Id of the block the warp belongs to |
| warp_idx | output | 5 | Warp number within the block |
| warp_tbase | output | 11 | Linear index of the warp's first thread |
| warp_rbase | output | 15 | Register-file word address of the warp's first thread |
| warp_mask | output | 32 | Active-lane mask |
| warp_last | output | 1 | Final warp of the block |

## Verification
A resource counter that leaks or double-counts does not show at once. It shows when a later request stalls that should fit, or is admitted when it should not. The bench drives each limit to its edge and then checks that a single retirement releases the stalled head in the very next cycle. A corrupted chunk map shows one cycle after the next admission as a wrong `warp_rbase` on warp 0. Allocations made after a gap has been opened in the map expose a faulty first-fit search. Mistakes in warp splitting show in `warp_tbase`, `warp_mask` and `warp_last` within W cycles of acceptance, where W is the block's warp count.

// File: rtl/blkadm_pkg.sv
package blkadm_pkg;
  localparam int DIMX_W = 10;
  localparam int DIMY_W = 10;
  localparam int DIMZ_W = 6;
  localparam int REGS_W = 8;
  localparam int WIDE_W = 40;

  typedef struct packed {
    logic [DIMX_W-1:0] dx;
    logic [DIMY_W-1:0] dy;
    logic [DIMZ_W-1:0] dz;
  } shape_t;

  typedef logic [WIDE_W-1:0] wide_t;

  typedef enum logic {
    EMIT_IDLE = 1'b0,
    EMIT_BUSY = 1'b1
  } emit_state_t;
endpackage

// File: rtl/blk_sizer.sv
module blk_sizer
  import blkadm_pkg::*;
#(
  parameter int WARP_SIZE   = 32,
  parameter int CHUNK_WORDS = 256
) (
  input  shape_t            shape,
  input  logic [REGS_W-1:0] regs,
  output wide_t             threads,
  output wide_t             warps,
  output wide_t             chunks
);
  localparam int WS_SH = $clog2(WARP_SIZE);
  localparam int CK_SH = $clog2(CHUNK_WORDS);

  wide_t words;

  always_comb begin
    threads = WIDE_W'(shape.dx) * WIDE_W'(shape.dy) * WIDE_W'(shape.dz);
    warps   = (threads + WIDE_W'(WARP_SIZE - 1)) >> WS_SH;
    words   = threads * WIDE_W'(regs);
    chunks  = (words + WIDE_W'(CHUNK_WORDS - 1)) >> CK_SH;
  end
endmodule

// File: rtl/blk_chunk_alloc.sv
module blk_chunk_alloc
  import blkadm_pkg::*;
#(
  parameter int NCHUNK = 128,
  localparam int CW = $clog2(NCHUNK),
  localparam int NW = $clog2(NCHUNK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wide_t         need,
  input  logic          alloc_en,
  input  logic          free_en,
  input  logic [CW-1:0] free_start,
  input  logic [NW-1:0] free_cnt,
  output logic          fit,
  output logic [CW-1:0] start
);
  logic [NCHUNK-1:0] used_q, used_d;
  logic [NCHUNK-1:0] amask, fmask;
  logic              need_ok, found;
  int                need_i, start_i, run, rstart;

  // first-fit search over the chunk map
  always_comb begin
    need_ok = (need <= WIDE_W'(NCHUNK));
    need_i  = need_ok ? int'(need[NW-1:0]) : 0;
    found   = (need_i == 0);
    start_i = 0;
    run     = 0;
    rstart  = 0;
    for (int i = 0; i < NCHUNK; i++) begin
      if (!found) begin
        if (used_q[i]) begin
          run = 0;
        end else begin
          if (run == 0) rstart = i;
          run = run + 1;
          if (run == need_i) begin
            found   = 1'b1;
            start_i = rstart;
          end
        end
      end
    end
    fit   = need_ok && found;
    start = CW'(start_i);
  end

  always_comb begin
    for (int i = 0; i < NCHUNK; i++) begin
      amask[i] = alloc_en && (i >= start_i) && (i < start_i + need_i);
      fmask[i] = free_en && (i >= int'(free_start)) &&
                 (i < int'(free_start) + int'(free_cnt));
    end
    used_d = (used_q & ~fmask) | amask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end
endmodule

// File: rtl/blk_slot_table.sv
module blk_slot_table #(
  parameter int NSLOT = 8,
  parameter int ID_W  = 8,
  parameter int WUW   = 6,
  parameter int TUW   = 11,
  parameter int CW    = 7,
  parameter int NW    = 8,
  localparam int SIW  = $clog2(NSLOT),
  localparam int BUW  = $clog2(NSLOT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic [ID_W-1:0] acc_id,
  input  logic [WUW-1:0]  acc_warps,
  input  logic [TUW-1:0]  acc_threads,
  input  logic [CW-1:0]   acc_cstart,
  input  logic [NW-1:0]   acc_ccnt,
  input  logic            ret_en,
  input  logic [ID_W-1:0] ret_id,
  output logic            slot_free,
  output logic [BUW-1:0]  blocks_used,
  output logic [WUW-1:0]  warps_used,
  output logic [TUW-1:0]  threads_used,
  output logic            ret_hit,
  output logic [CW-1:0]   ret_cstart,
  output logic [NW-1:0]   ret_ccnt
);
  logic [NSLOT-1:0] vld_q, vld_d;
  logic [ID_W-1:0]  sid    [NSLOT];
  logic [WUW-1:0]   swarps [NSLOT];
  logic [TUW-1:0]   sthr   [NSLOT];
  logic [CW-1:0]    scst   [NSLOT];
  logic [NW-1:0]    sccnt  [NSLOT];
  logic [SIW-1:0]   acc_slot, ret_slot;
  logic [BUW-1:0]   bu_d;
  logic [WUW-1:0]   wu_d;
  logic [TUW-1:0]   tu_d;

  always_comb begin
    slot_free = 1'b0;
    acc_slot  = '0;
    ret_hit   = 1'b0;
    ret_slot  = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (!vld_q[s]) begin
        slot_free = 1'b1;
        acc_slot  = SIW'(s);
      end
      if (ret_en && vld_q[s] && sid[s] == ret_id) begin
        ret_hit  = 1'b1;
        ret_slot = SIW'(s);
      end
    end
    ret_cstart = scst[ret_slot];
    ret_ccnt   = sccnt[ret_slot];
  end

  always_comb begin
    vld_d = vld_q;
    bu_d  = blocks_used;
    wu_d  = warps_used;
    tu_d  = threads_used;
    if (acc_en) begin
      vld_d[acc_slot] = 1'b1;
      bu_d = bu_d + BUW'(1);
      wu_d = wu_d + acc_warps;
      tu_d = tu_d + acc_threads;
    end
    if (ret_hit) begin
      vld_d[ret_slot] = 1'b0;
      bu_d = bu_d - BUW'(1);
      wu_d = wu_d - swarps[ret_slot];
      tu_d = tu_d - sthr[ret_slot];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q        <= '0;
      blocks_used  <= '0;
      warps_used   <= '0;
      threads_used <= '0;
    end else begin
      vld_q        <= vld_d;
      blocks_used  <= bu_d;
      warps_used   <= wu_d;
      threads_used <= tu_d;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (acc_en && acc_slot == SIW'(g)) begin
        sid[g]    <= acc_id;
        swarps[g] <= acc_warps;
        sthr[g]   <= acc_threads;
        scst[g]   <= acc_cstart;
        sccnt[g]  <= acc_ccnt;
      end
    end
  end
endmodule

// File: rtl/blk_warp_emit.sv
module blk_warp_emit
  import blkadm_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int WARP_SIZE = 32,
  parameter int WUW       = 6,
  parameter int WIX_W     = 5,
  parameter int TUW       = 11,
  parameter int TB_W      = 11,
  parameter int RB_W      = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [ID_W-1:0]      ld_id,
  input  logic [TUW-1:0]       ld_threads,
  input  logic [WUW-1:0]       ld_warps,
  input  logic [REGS_W-1:0]    ld_regs,
  input  logic [RB_W-1:0]      ld_rbase,
  output logic                 busy,
  output logic                 warp_valid,
  output logic [ID_W-1:0]      warp_block,
  output logic [WIX_W-1:0]     warp_idx,
  output logic [TB_W-1:0]      warp_tbase,
  output logic [RB_W-1:0]      warp_rbase,
  output logic [WARP_SIZE-1:0] warp_mask,
  output logic                 warp_last
);
  emit_state_t        st_q, st_d;
  logic [WUW-1:0]     k_q, k_d;
  logic [ID_W-1:0]    id_q, id_d;
  logic [TUW-1:0]     thr_q, thr_d;
  logic [WUW-1:0]     nw_q, nw_d;
  logic [REGS_W-1:0]  rg_q, rg_d;
  logic [RB_W-1:0]    rb_q, rb_d;
  logic [31:0]        first_thr, rb_off, rem;
  logic               at_last;

  assign at_last = (k_q == nw_q - WUW'(1));

  always_comb begin
    st_d  = st_q;
    k_d   = k_q;
    id_d  = id_q;
    thr_d = thr_q;
    nw_d  = nw_q;
    rg_d  = rg_q;
    rb_d  = rb_q;
    if (st_q == EMIT_IDLE) begin
      if (load) begin
        st_d  = EMIT_BUSY;
        k_d   = '0;
        id_d  = ld_id;
        thr_d = ld_threads;
        nw_d  = ld_warps;
        rg_d  = ld_regs;
        rb_d  = ld_rbase;
      end
    end else if (at_last) begin
      st_d = EMIT_IDLE;
    end else begin
      k_d = k_q + WUW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= EMIT_IDLE;
      k_q  <= '0;
    end else begin
      st_q <= st_d;
      k_q  <= k_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load && st_q == EMIT_IDLE) begin
      id_q  <= id_d;
      thr_q <= thr_d;
      nw_q  <= nw_d;
      rg_q  <= rg_d;
      rb_q  <= rb_d;
    end
  end

  always_comb begin
    first_thr  = 32'(k_q) * 32'(WARP_SIZE);
    rb_off     = first_thr * 32'(rg_q);
    rem        = 32'(thr_q) - first_thr;
    busy       = (st_q == EMIT_BUSY);
    warp_valid = busy;
    warp_block = id_q;
    warp_idx   = k_q[WIX_W-1:0];
    warp_tbase = first_thr[TB_W-1:0];
    warp_rbase = rb_q + rb_off[RB_W-1:0];
    warp_last  = busy && at_last;
    for (int j = 0; j < WARP_SIZE; j++) begin
      warp_mask[j] = busy && (32'(j) < rem);
    end
  end
endmodule

// File: rtl/block_admit.sv
module block_admit
  import blkadm_pkg::*;
#(
  parameter int NBLK        = 8,
  parameter int MAX_WARPS   = 32,
  parameter int MAX_THREADS = 1536,
  parameter int WARP_SIZE   = 32,
  parameter int RF_WORDS    = 32768,
  parameter int CHUNK_WORDS = 256,
  parameter int ID_W        = 8,
  localparam int NCHUNK = RF_WORDS / CHUNK_WORDS,
  localparam int CW     = $clog2(NCHUNK),
  localparam int NW     = $clog2(NCHUNK + 1),
  localparam int CK_SH  = $clog2(CHUNK_WORDS),
  localparam int BUW    = $clog2(NBLK + 1),
  localparam int WUW    = $clog2(MAX_WARPS + 1),
  localparam int TUW    = $clog2(MAX_THREADS + 1),
  localparam int WIX_W  = $clog2(MAX_WARPS),
  localparam int TB_W   = $clog2(MAX_THREADS),
  localparam int RB_W   = $clog2(RF_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ID_W-1:0]      req_id,
  input  logic [DIMX_W-1:0]    req_dx,
  input  logic [DIMY_W-1:0]    req_dy,
  input  logic [DIMZ_W-1:0]    req_dz,
  input  logic [REGS_W-1:0]    req_regs,
  input  logic                 ret_valid,
  input  logic [ID_W-1:0]      ret_id,
  output logic                 warp_valid,
  output logic [ID_W-1:0]      warp_block,
  output logic [WIX_W-1:0]     warp_idx,
  output logic [TB_W-1:0]      warp_tbase,
  output logic [RB_W-1:0]      warp_rbase,
  output logic [WARP_SIZE-1:0] warp_mask,
  output logic                 warp_last
);
  logic [1:0]      rst_sync;
  logic            rst_ni;
  shape_t          shape;
  wide_t           thr_need, warp_need, chunk_need;
  logic            chunk_fit, slot_free, busy, accept, lim_ok;
  logic [CW-1:0]   cstart;
  logic [BUW-1:0]  blocks_used;
  logic [WUW-1:0]  warps_used;
  logic [TUW-1:0]  threads_used;
  logic            ret_hit;
  logic [CW-1:0]   ret_cstart;
  logic [NW-1:0]   ret_ccnt;
  logic [RB_W-1:0] rbase_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign shape = '{dx: req_dx, dy: req_dy, dz: req_dz};

  blk_sizer #(.WARP_SIZE(WARP_SIZE), .CHUNK_WORDS(CHUNK_WORDS)) u_size (
    .shape(shape), .regs(req_regs),
    .threads(thr_need), .warps(warp_need), .chunks(chunk_need)
  );

  always_comb begin
    lim_ok = slot_free &&
             (WIDE_W'(blocks_used) < WIDE_W'(NBLK)) &&
             (WIDE_W'(warps_used) + warp_need <= WIDE_W'(MAX_WARPS)) &&
             (WIDE_W'(threads_used) + thr_need <= WIDE_W'(MAX_THREADS));
    req_ready  = !busy && lim_ok && chunk_fit;
    accept     = req_valid && req_ready;
    rbase_word = {cstart, {CK_SH{1'b0}}};
  end

  blk_chunk_alloc #(.NCHUNK(NCHUNK)) u_chunks (
    .clk(clk), .rst_n(rst_ni), .need(chunk_need), .alloc_en(accept),
    .free_en(ret_hit), .free_start(ret_cstart), .free_cnt(ret_ccnt),
    .fit(chunk_fit), .start(cstart)
  );

  blk_slot_table #(
    .NSLOT(NBLK), .ID_W(ID_W), .WUW(WUW), .TUW(TUW), .CW(CW), .NW(NW)
  ) u_slots (
    .clk(clk), .rst_n(rst_ni),
    .acc_en(accept), .acc_id(req_id),
    .acc_warps(WUW'(warp_need)), .acc_threads(TUW'(thr_need)),
    .acc_cstart(cstart), .acc_ccnt(NW'(chunk_need)),
    .ret_en(ret_valid), .ret_id(ret_id),
    .slot_free(slot_free), .blocks_used(blocks_used),
    .warps_used(warps_used), .threads_used(threads_used),
    .ret_hit(ret_hit), .ret_cstart(ret_cstart), .ret_ccnt(ret_ccnt)
  );

  blk_warp_emit #(
    .ID_W(ID_W), .WARP_SIZE(WARP_SIZE), .WUW(WUW), .WIX_W(WIX_W),
    .TUW(TUW), .TB_W(TB_W), .RB_W(RB_W)
  ) u_emit (
    .clk(clk), .rst_n(rst_ni), .load(accept), .ld_id(req_id),
    .ld_threads(TUW'(thr_need)), .ld_warps(WUW'(warp_need)),
    .ld_regs(req_regs), .ld_rbase(rbase_word), .busy(busy),
    .warp_valid(warp_valid), .warp_block(warp_block), .warp_idx(warp_idx),
    .warp_tbase(warp_tbase), .warp_rbase(warp_rbase),
    .warp_mask(warp_mask), .warp_last(warp_last)
  );
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
  parameter int NBLK        = 8,
  parameter int MAX_WARPS   = 32,
  parameter int MAX_THREADS = 1536,
  parameter int WARP_SIZE   = 32,
  parameter int BUW         = 4,
  parameter int WUW         = 6,
  parameter int TUW         = 11,
  parameter int WIX_W       = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 warp_valid,
  input logic [WIX_W-1:0]     warp_idx,
  input logic [WARP_SIZE-1:0] warp_mask,
  input logic                 warp_last,
  input logic [BUW-1:0]       blocks_used,
  input logic [WUW-1:0]       warps_used,
  input logic [TUW-1:0]       threads_used
);
  // R4: first warp follows acceptance by one cycle
  a_r4_first_warp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (warp_valid && warp_idx == '0));

  // R4: warps of one block come back to back with rising index
  a_r4_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (warp_valid && !warp_last) |=>
      (warp_valid && warp_idx == $past(warp_idx) + WIX_W'(1)));

  // R9: no admission while warps are presented
  a_r9_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
    warp_valid |-> !req_ready);

  // R6: non-final warps are full; every warp has lane 0 active
  a_r6_full_warp: assert property (@(posedge clk) disable iff (!rst_n)
    (warp_valid && !warp_last) |-> (&warp_mask));
  a_r6_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    warp_valid |-> warp_mask[0]);

  // R2: residency counters never exceed their limits
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(blocks_used) <= NBLK) && (32'(warps_used) <= MAX_WARPS) &&
    (32'(threads_used) <= MAX_THREADS));
endmodule

bind block_admit blk_admit_chk #(
  .NBLK(NBLK), .MAX_WARPS(MAX_WARPS), .MAX_THREADS(MAX_THREADS),
  .WARP_SIZE(WARP_SIZE), .BUW(BUW), .WUW(WUW), .TUW(TUW), .WIX_W(WIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .warp_valid(warp_valid), .warp_idx(warp_idx), .warp_mask(warp_mask),
  .warp_last(warp_last), .blocks_used(blocks_used),
  .warps_used(warps_used), .threads_used(threads_used)
);

// File: tb/sim_block_admit.sv
module sim_block_admit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [7:0]  req_id;
  logic [9:0]  req_dx, req_dy;
  logic [5:0]  req_dz;
  logic [7:0]  req_regs;
  logic        ret_valid;
  logic [7:0]  ret_id;
  logic        warp_valid, warp_last;
  logic [7:0]  warp_block;
  logic [4:0]  warp_idx;
  logic [10:0] warp_tbase;
  logic [14:0] warp_rbase;
  logic [31:0] warp_mask;

  always #5 clk = ~clk;

  block_admit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_dx(req_dx), .req_dy(req_dy), .req_dz(req_dz),
    .req_regs(req_regs), .ret_valid(ret_valid), .ret_id(ret_id),
    .warp_valid(warp_valid), .warp_block(warp_block), .warp_idx(warp_idx),
    .warp_tbase(warp_tbase), .warp_rbase(warp_rbase),
    .warp_mask(warp_mask), .warp_last(warp_last)
  );

  typedef struct {
    int          id;
    int          idx;
    int          tb;
    int          rb;
    logic [31:0] mask;
    bit          last;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (mon_en && warp_valid) begin
      chk(req_ready == 1'b0, "R9", "ready during emission", req_ready, 0);
      if (q.size() == 0) begin
        chk(1'b0, "R4", "unexpected warp of block", warp_block, -1);
      end else begin
        e = q.pop_front();
        chk(warp_block == 8'(e.id), "R4", "block id", warp_block, e.id);
        chk(int'(warp_idx) == e.idx, "R4", "warp index", warp_idx, e.idx);
        chk(warp_last == e.last, "R4", "last flag", warp_last, e.last);
        chk(int'(warp_tbase) == e.tb, "R5", "thread base", warp_tbase, e.tb);
        chk(warp_mask == e.mask, "R6", "lane mask", warp_mask, e.mask);
        chk(int'(warp_rbase) == e.rb, "R7", "register base", warp_rbase, e.rb);
      end
    end
  end

  task automatic push_block(input int id, input int t, input int regs,
                            input int start);
    int w;
    w = (t + 31) / 32;
    for (int k = 0; k < w; k++) begin
      exp_t e;
      int rem;
      rem    = t - 32 * k;
      e.id   = id;
      e.idx  = k;
      e.tb   = 32 * k;
      e.rb   = start * 256 + 32 * k * regs;
      e.mask = (rem >= 32) ? 32'hFFFF_FFFF : 32'((64'(1) << rem) - 1);
      e.last = (k == w - 1);
      q.push_back(e);
    end
  endtask

  task automatic drive_req(input int id, input int dx, input int dy,
                           input int dz, input int regs);
    req_id    = 8'(id);
    req_dx    = 10'(dx);
    req_dy    = 10'(dy);
    req_dz    = 6'(dz);
    req_regs  = 8'(regs);
    req_valid = 1'b1;
  endtask

  // called just after a falling edge
  task automatic wait_accept();
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || warp_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input int id, input int dx, input int dy, input int dz,
                      input int regs, input int start);
    push_block(id, dx * dy * dz, regs, start);
    @(negedge clk);
    drive_req(id, dx, dy, dz, regs);
    wait_accept();
    drain();
  endtask

  task automatic stall(input int id, input int dx, input int dy, input int dz,
                       input int regs, input int start, input string req);
    push_block(id, dx * dy * dz, regs, start);
    @(negedge clk);
    drive_req(id, dx, dy, dz, regs);
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(req_ready == 1'b0, req, "stalled head ready", req_ready, 0);
      @(negedge clk);
    end
  endtask

  task automatic retire(input int id);
    @(negedge clk);
    ret_valid = 1'b1;
    ret_id    = 8'(id);
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    ret_valid = 1'b0;
    ret_id    = '0;
    drive_req(0, 1, 1, 1, 0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(warp_valid == 1'b0, "R1", "warp valid in reset", warp_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(warp_valid == 1'b0, "R1", "warp valid after reset", warp_valid, 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    mon_en = 1'b1;

    // R4 R5 R6 R7: 45 threads, partial second warp, 2 chunks at 0
    send(1, 5, 3, 3, 10, 0);
    // R7: 128 threads x 20 regs = 10 chunks right after
    send(2, 8, 8, 2, 20, 2);
    // R10: no registers
    send(3, 16, 1, 1, 0, 0);
    // R8 R7: freeing block 1 opens chunks 0..1, first fit reuses them
    retire(1);
    send(4, 32, 1, 1, 16, 0);
    send(5, 32, 1, 1, 24, 12);
    // R2 block limit: fill to eight resident blocks
    send(6, 1, 1, 1, 0, 0);
    send(7, 1, 1, 1, 0, 0);
    send(8, 1, 1, 1, 0, 0);
    send(9, 1, 1, 1, 0, 0);
    stall(10, 1, 1, 1, 0, 0, "R2");
    retire(200);
    #1;
    chk(req_ready == 1'b0, "R8", "ready after unmatched retire", req_ready, 0);
    retire(6);
    #1;
    chk(req_ready == 1'b1, "R3", "ready after freeing slot", req_ready, 1);
    wait_accept();
    drain();
    retire(2); retire(3); retire(4); retire(5);
    retire(7); retire(8); retire(9); retire(10);

    // R2 warp limit: two 16-warp blocks fill 32 warps
    send(11, 16, 16, 2, 0, 0);
    send(12, 16, 16, 2, 0, 0);
    stall(13, 1, 1, 1, 0, 0, "R2");
    retire(11);
    #1;
    chk(req_ready == 1'b1, "R3", "ready after freeing warps", req_ready, 1);
    wait_accept();
    drain();
    retire(12); retire(13);

    // R2 register limit: two blocks take all 128 chunks
    send(14, 16, 16, 1, 64, 0);
    send(15, 16, 16, 1, 64, 64);
    stall(16, 32, 1, 1, 8, 0, "R2");
    retire(14);
    #1;
    chk(req_ready == 1'b1, "R3", "ready after freeing chunks", req_ready, 1);
    wait_accept();
    drain();
    // R7: next fit lands after the one-chunk block
    send(17, 32, 1, 1, 64, 1);

    drain();
    chk(q.size() == 0, "R4", "outstanding expected warps", q.size(), 0);
    finish_run();
  end
endmodule